// File: doc/BRIEF.md
# Radar Sector Echo Characterizer

This block reads a stream of digitized radar echo samples, each tagged with the range bin and antenna azimuth it belongs to. It looks at a rectangular window of the scan, set by a lower and upper range index and a lower and upper azimuth. Every range cell is reduced to one intensity: the mean of 32 consecutive samples taken at that range during one azimuth step. Inside the window the block compares each intensity with a threshold. It counts the covered cells, sums their intensities, and sums the absolute intensity steps towards the neighbouring cell in range and the neighbouring cell in azimuth.

Gradients are formed while the data streams through. The previous range cell is held in a register. The previous azimuth row sits in a line buffer indexed by range, which block RAM can hold. No frame is stored. A step between two cells counts only when at least one of the pair lies above the threshold.

The window is closed by the first cell whose azimuth lies past the upper azimuth bound. An iterative divider then forms the two means. The block emits seven words on consecutive cycles: the four window coordinates, then the area, the mean intensity and the mean gradient.

Top module: `sector_echo_char`

## Requirements
- R1: A cell intensity is floor(S/32), where S is the sum of 32 consecutive accepted samples (`smp_valid` high). The cell takes its range and azimuth from the 32nd sample.
- R2: A cell inside the window is covered when its intensity is strictly greater than `cfg_thresh`. The area is the number of covered cells in the window.
- R3: The intensity sum takes covered cells only. The mean intensity is floor(sum/area), so it never exceeds 255.
- R4: For every window cell with range above `cfg_rng_lo`, the term |I(r,a) − I(r−1,a)| is added to the gradient sum when either cell exceeds the threshold.
- R5: For every window cell with azimuth above `cfg_az_lo`, the term |I(r,a) − I(r,a−1)| is added to the gradient sum when either cell exceeds the threshold. The previous row is taken from a line buffer indexed by range.
- R6: The mean gradient is floor(gradient sum / area).
- R7: A sector opens, with all accumulators cleared, when a cell at range `cfg_rng_lo` and azimuth `cfg_az_lo` completes while the block is idle. Cells outside the window have no effect on any result.
- R8: The first completed cell with azimuth greater than `cfg_az_hi` closes the sector. The block then drives `out_valid` for exactly seven consecutive cycles, with `out_idx` 0..6 carrying, in order: range low, range high, azimuth low, azimuth high, area, mean intensity, mean gradient. `out_valid` is low after reset.
- R9: When the area is zero, both means are output as 0 and `out_empty` is 1 on all seven words. Otherwise `out_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Unsigned echo sample |
| smp_range | input | 6 | Range index of the sample |
| smp_azim | input | 9 | Azimuth index of the sample |
| cfg_rng_lo | input | 6 | Lower range bound (inclusive) |
| cfg_rng_hi | input | 6 | Upper range bound (inclusive) |
| cfg_az_lo | input | 9 | Lower azimuth bound (inclusive) |
| cfg_az_hi | input | 9 | Upper azimuth bound (inclusive) |
| cfg_thresh | input | 8 | Coverage threshold |
| out_valid | output | 1 | Result word valid |
| out_idx | output | 3 | Index of the result word (0..6) |
| out_word | output | 24 | Result word, zero-extended |
| out_empty | output | 1 | Area was zero |

## Verification
The assertions rely on the configuration staying constant from sector start until the last result word, and on cells arriving in groups of 32 samples. Within a row the range indices must rise by one, and each row must follow the previous azimuth by one. The stimulus sends every row over the full range span in that order. It holds the bounds fixed for each sector and sends only one cell of the closing row, so that the results come out while the input is quiet. Random sample gaps, high-valued cells outside the window and extreme thresholds keep the inputs within those limits and still reach the corner cases.

// File: rtl/sector_pkg.sv
package sector_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_DIVI = 3'd2,
    ST_DIVG = 3'd3,
    ST_EMIT = 3'd4
  } sec_state_t;

  localparam int OUT_WORDS = 7;
endpackage

// File: rtl/sector_cell_avg.sv
module sector_cell_avg #(
  parameter int SW   = 8,
  parameter int RW   = 6,
  parameter int AZW  = 9,
  parameter int NAVG = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [SW-1:0]  in_data,
  input  logic [RW-1:0]  in_range,
  input  logic [AZW-1:0] in_azim,
  output logic           cell_valid,
  output logic [SW-1:0]  cell_int,
  output logic [RW-1:0]  cell_rng,
  output logic [AZW-1:0] cell_az
);
  localparam int LG  = $clog2(NAVG);
  localparam int SUW = SW + LG;

  logic [LG-1:0]  cnt;
  logic [SUW-1:0] sum;
  logic [SUW-1:0] total;

  assign total = sum + SUW'(in_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      sum        <= '0;
      cell_valid <= 1'b0;
      cell_int   <= '0;
      cell_rng   <= '0;
      cell_az    <= '0;
    end else begin
      cell_valid <= 1'b0;
      if (in_valid) begin
        if (cnt == LG'(NAVG - 1)) begin
          cnt        <= '0;
          sum        <= '0;
          cell_valid <= 1'b1;
          cell_int   <= SW'(total >> LG);
          cell_rng   <= in_range;
          cell_az    <= in_azim;
        end else begin
          cnt <= cnt + 1'b1;
          sum <= total;
        end
      end
    end
  end
endmodule

// File: rtl/sector_line_buf.sv
module sector_line_buf #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sector_divider.sv
module sector_divider #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W);

  logic [W:0]    rem;
  logic [W-1:0]  dsr;
  logic [W:0]    rem_sh;
  logic [CW-1:0] cnt;
  logic          busy;

  assign rem_sh = {rem[W-1:0], quotient[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      rem      <= '0;
      dsr      <= '0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        cnt      <= '0;
        rem      <= '0;
        dsr      <= divisor;
        quotient <= dividend;
      end else if (busy) begin
        if (rem_sh >= {1'b0, dsr}) begin
          rem      <= rem_sh - {1'b0, dsr};
          quotient <= {quotient[W-2:0], 1'b1};
        end else begin
          rem      <= rem_sh;
          quotient <= {quotient[W-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sector_echo_char.sv
module sector_echo_char
  import sector_pkg::*;
#(
  parameter int SW   = 8,
  parameter int RW   = 6,
  parameter int AZW  = 9,
  parameter int AW   = 24,
  parameter int NAVG = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_valid,
  input  logic [SW-1:0]  smp_data,
  input  logic [RW-1:0]  smp_range,
  input  logic [AZW-1:0] smp_azim,
  input  logic [RW-1:0]  cfg_rng_lo,
  input  logic [RW-1:0]  cfg_rng_hi,
  input  logic [AZW-1:0] cfg_az_lo,
  input  logic [AZW-1:0] cfg_az_hi,
  input  logic [SW-1:0]  cfg_thresh,
  output logic           out_valid,
  output logic [2:0]     out_idx,
  output logic [AW-1:0]  out_word,
  output logic           out_empty
);
  logic           cell_v;
  logic [SW-1:0]  cell_int;
  logic [RW-1:0]  cell_rng;
  logic [AZW-1:0] cell_az;
  logic [SW-1:0]  up_int;
  logic [SW-1:0]  prev_int;

  sec_state_t     state;
  logic [AW-1:0]  acc_area, acc_int, acc_grad;
  logic [AW-1:0]  mean_i, mean_g;
  logic           empty_q;
  logic [2:0]     emit_cnt;

  logic           div_start, div_done;
  logic [AW-1:0]  div_dvd, div_q;

  sector_cell_avg #(.SW(SW), .RW(RW), .AZW(AZW), .NAVG(NAVG)) avg_i (
    .clk(clk), .rst(rst),
    .in_valid(smp_valid), .in_data(smp_data),
    .in_range(smp_range), .in_azim(smp_azim),
    .cell_valid(cell_v), .cell_int(cell_int),
    .cell_rng(cell_rng), .cell_az(cell_az)
  );

  logic in_win, start_c, proc_c, fin_c;
  logic cur_hi, prev_hi, up_hi;
  logic use_rng, use_az;
  logic [SW-1:0] d_rng, d_az;
  logic [AW-1:0] area_nx, int_nx, grad_nx;
  logic [AW-1:0] base_area, base_int, base_grad;

  assign in_win  = (cell_rng >= cfg_rng_lo) && (cell_rng <= cfg_rng_hi) &&
                   (cell_az  >= cfg_az_lo)  && (cell_az  <= cfg_az_hi);
  assign start_c = cell_v && (state == ST_IDLE) &&
                   (cell_rng == cfg_rng_lo) && (cell_az == cfg_az_lo);
  assign proc_c  = cell_v && in_win && ((state == ST_RUN) || start_c);
  assign fin_c   = cell_v && (state == ST_RUN) && (cell_az > cfg_az_hi);

  sector_line_buf #(.DW(SW), .AW(RW)) lbuf_i (
    .clk(clk),
    .we(proc_c), .waddr(cell_rng), .wdata(cell_int),
    .re(smp_valid), .raddr(smp_range), .rdata(up_int)
  );

  assign cur_hi  = cell_int > cfg_thresh;
  assign prev_hi = prev_int > cfg_thresh;
  assign up_hi   = up_int   > cfg_thresh;
  assign use_rng = (cell_rng != cfg_rng_lo) && (cur_hi || prev_hi);
  assign use_az  = (cell_az  != cfg_az_lo)  && (cur_hi || up_hi);
  assign d_rng   = (cell_int >= prev_int) ? cell_int - prev_int : prev_int - cell_int;
  assign d_az    = (cell_int >= up_int)   ? cell_int - up_int   : up_int   - cell_int;

  assign base_area = start_c ? '0 : acc_area;
  assign base_int  = start_c ? '0 : acc_int;
  assign base_grad = start_c ? '0 : acc_grad;
  assign area_nx   = base_area + (cur_hi ? AW'(1) : '0);
  assign int_nx    = base_int  + (cur_hi ? AW'(cell_int) : '0);
  assign grad_nx   = base_grad + (use_rng ? AW'(d_rng) : '0)
                               + (use_az  ? AW'(d_az)  : '0);

  always_comb begin
    div_start = 1'b0;
    div_dvd   = acc_int;
    if (fin_c && acc_area != '0) begin
      div_start = 1'b1;
    end else if (state == ST_DIVI && div_done) begin
      div_start = 1'b1;
      div_dvd   = acc_grad;
    end
  end

  sector_divider #(.W(AW)) div_i (
    .clk(clk), .rst(rst),
    .start(div_start), .dividend(div_dvd), .divisor(acc_area),
    .done(div_done), .quotient(div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      acc_area <= '0;
      acc_int  <= '0;
      acc_grad <= '0;
      prev_int <= '0;
      mean_i   <= '0;
      mean_g   <= '0;
      empty_q  <= 1'b0;
      emit_cnt <= '0;
    end else begin
      if (proc_c) begin
        acc_area <= area_nx;
        acc_int  <= int_nx;
        acc_grad <= grad_nx;
        prev_int <= cell_int;
      end
      unique case (state)
        ST_IDLE: if (start_c) state <= ST_RUN;
        ST_RUN: if (fin_c) begin
          emit_cnt <= '0;
          if (acc_area == '0) begin
            mean_i  <= '0;
            mean_g  <= '0;
            empty_q <= 1'b1;
            state   <= ST_EMIT;
          end else begin
            empty_q <= 1'b0;
            state   <= ST_DIVI;
          end
        end
        ST_DIVI: if (div_done) begin
          mean_i <= div_q;
          state  <= ST_DIVG;
        end
        ST_DIVG: if (div_done) begin
          mean_g <= div_q;
          state  <= ST_EMIT;
        end
        ST_EMIT: begin
          emit_cnt <= emit_cnt + 1'b1;
          if (emit_cnt == 3'(OUT_WORDS - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_word  <= '0;
      out_empty <= 1'b0;
    end else begin
      out_valid <= (state == ST_EMIT);
      out_idx   <= emit_cnt;
      out_empty <= empty_q;
      unique case (emit_cnt)
        3'd0:    out_word <= AW'(cfg_rng_lo);
        3'd1:    out_word <= AW'(cfg_rng_hi);
        3'd2:    out_word <= AW'(cfg_az_lo);
        3'd3:    out_word <= AW'(cfg_az_hi);
        3'd4:    out_word <= acc_area;
        3'd5:    out_word <= mean_i;
        default: out_word <= mean_g;
      endcase
    end
  end
endmodule

// File: rtl/sector_echo_char_chk.sv
module sector_echo_char_chk #(
  parameter int RW = 6,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic [2:0]    out_idx,
  input logic [AW-1:0] out_word,
  input logic          out_empty,
  input logic [RW-1:0] cfg_rng_lo
);
  AST_IDX_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_idx == 3'd0); // R8
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx != 3'd6) |=> (out_valid && out_idx == $past(out_idx) + 3'd1)); // R8
  AST_IDX_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx == 3'd6) |=> !out_valid); // R8
  AST_RNG_ECHO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx == 3'd0) |-> out_word == AW'(cfg_rng_lo)); // R8
  AST_EMPTY_AREA: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx == 3'd4) |-> ((out_word == '0) == out_empty)); // R9
  AST_EMPTY_MEANS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_empty && out_idx >= 3'd5) |-> out_word == '0); // R9
  AST_MEAN_INT_MAX: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx == 3'd5) |-> out_word <= AW'(255)); // R3
  AST_EMPTY_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx != 3'd0) |-> $stable(out_empty)); // R9
endmodule

bind sector_echo_char sector_echo_char_chk #(.RW(RW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_idx(out_idx),
  .out_word(out_word), .out_empty(out_empty), .cfg_rng_lo(cfg_rng_lo)
);

// File: tb/sector_echo_char_tb_top.sv
`timescale 1ns/1ps
module sector_echo_char_tb_top;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_data = '0;
  logic [5:0]  smp_range = '0;
  logic [8:0]  smp_azim = '0;
  logic [5:0]  cfg_rng_lo = '0, cfg_rng_hi = '0;
  logic [8:0]  cfg_az_lo = '0, cfg_az_hi = '0;
  logic [7:0]  cfg_thresh = '0;
  logic        out_valid;
  logic [2:0]  out_idx;
  logic [23:0] out_word;
  logic        out_empty;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int img [0:63][0:NR-1];

  always #5 clk = ~clk;

  sector_echo_char dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_range(smp_range), .smp_azim(smp_azim),
    .cfg_rng_lo(cfg_rng_lo), .cfg_rng_hi(cfg_rng_hi),
    .cfg_az_lo(cfg_az_lo), .cfg_az_hi(cfg_az_hi), .cfg_thresh(cfg_thresh),
    .out_valid(out_valid), .out_idx(out_idx), .out_word(out_word),
    .out_empty(out_empty)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL R8 watchdog expired: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // R1: 32 samples around base; returns floor(sum/32)
  task automatic send_cell(input int r, input int a, input int base);
    int sum = 0;
    for (int k = 0; k < 32; k++) begin
      int v = base + int'($urandom % 9) - 4;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      sum += v;
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 8'(v);
      smp_range = 6'(r);
      smp_azim  = 9'(a);
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        smp_valid = 1'b0;
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    img[a][r] = sum / 32;
  endtask

  task automatic run_sector(input int rl, input int rh, input int al, input int ah,
                            input int h, input int mode);
    int area = 0, isum = 0, gsum = 0;
    int exp_w [0:6];
    bit seen = 0;
    cfg_rng_lo = 6'(rl); cfg_rng_hi = 6'(rh);
    cfg_az_lo = 9'(al);  cfg_az_hi = 9'(ah);
    cfg_thresh = 8'(h);
    for (int a = al - 1; a <= ah; a++) begin
      for (int r = 0; r < NR; r++) begin
        int base;
        if (a < al || r < rl || r > rh) base = 200 + int'($urandom % 56); // R7 outside cells
        else if (mode == 1) base = (($urandom % 3) == 0) ? 0 : int'($urandom % 256);
        else if (mode == 2) base = 200;
        else base = int'($urandom % 256);
        send_cell(r, a, base);
      end
    end
    send_cell(0, ah + 1, 100); // R8 closing cell
    for (int a = al; a <= ah; a++) begin
      for (int r = rl; r <= rh; r++) begin
        int c = img[a][r];
        if (c > h) begin area++; isum += c; end
        if (r > rl && (c > h || img[a][r-1] > h)) gsum += absd(c, img[a][r-1]); // R4
        if (a > al && (c > h || img[a-1][r] > h)) gsum += absd(c, img[a-1][r]); // R5
      end
    end
    exp_w[0] = rl; exp_w[1] = rh; exp_w[2] = al; exp_w[3] = ah;
    exp_w[4] = area;
    exp_w[5] = (area == 0) ? 0 : isum / area;
    exp_w[6] = (area == 0) ? 0 : gsum / area;
    for (int t = 0; t < 400 && !seen; t++) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    check(seen, "R8 results appear", int'(seen), 1);
    if (seen) begin
      for (int i = 0; i < 7; i++) begin
        string tg;
        case (i)
          4: tg = "R2 area";
          5: tg = "R3 mean intensity";
          6: tg = "R6 mean gradient R4 R5";
          default: tg = "R8 bound echo";
        endcase
        check(out_valid && out_idx == 3'(i), "R8 word order", int'(out_idx), i);
        check(out_word == 24'(exp_w[i]), tg, int'(out_word), exp_w[i]);
        check(out_empty == (area == 0), "R9 empty flag", int'(out_empty), int'(area == 0));
        @(negedge clk);
      end
      check(!out_valid, "R8 seven words only", int'(out_valid), 0);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R8 reset state", int'(out_valid), 0);
    run_sector(2, 9, 5, 8, 255, 0);   // R9 nothing covered
    run_sector(0, 15, 12, 16, 0, 1);  // R2 strict compare with zero cells
    run_sector(4, 4, 30, 30, 50, 2);  // R7 single cell sector
    run_sector(3, 11, 40, 43, 120, 0);
    for (int s = 0; s < 3; s++) begin
      int rl = int'($urandom % 8);
      int rh = rl + int'($urandom % 8);
      int al = 1 + int'($urandom % 50);
      int ah = al + int'($urandom % 4);
      run_sector(rl, rh, al, ah, 60 + int'($urandom % 120), 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule